// File: doc/BRIEF.md
# Bit-Serial Cyclic Hamming(7,4) Encoder

This block turns each 4-bit message into a 7-bit systematic cyclic Hamming codeword. It sends the codeword one bit per clock with no gaps between codewords. The four message bits go out first, least significant message bit first. Three check bits follow them. A three-bit division register builds the check bits while the message bits are being sent. During the check phase that register shifts its contents onto the line.

A seven-phase sequencer raises `ready_o` once in every codeword. In that cycle the caller presents the next message and the block samples it. At all other times the message input is ignored. `valid_o` goes high at the first clock edge after reset and stays high. The serial output therefore carries a codeword bit in every cycle after that.

Top module: `serial_hamming_enc`

## Requirements
- R1: While reset is asserted, `ready_o` is 1, `valid_o` is 0 and `sdata_o` is 0. After reset is released, the first codeword starts in the next cycle.
- R2: `ready_o` is high for exactly one cycle in every seven, so consecutive rises of `ready_o` are seven cycles apart.
- R3: `valid_o` is 1 in every cycle after the first clock edge that follows reset release.
- R4: The message on `msg_i` is captured at the clock edge that ends a `ready_o` cycle. In the four cycles that follow, `sdata_o` carries `msg_i[0]`, `msg_i[1]`, `msg_i[2]` and `msg_i[3]`, in that order.
- R5: Values driven on `msg_i` while `ready_o` is 0 have no effect on the serial stream.
- R6: Three check bits follow the message bits on `sdata_o`. Read the seven bits of a codeword as a polynomial whose first-sent bit is the x^6 coefficient. That polynomial is divisible by g(x) = x^3 + x + 1.
- R7: Codewords follow each other with no idle cycle. The last check bit of one codeword appears in the same cycle as the `ready_o` that samples the next message, and an all-zero message gives seven zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| msg_i | input | 4 | Message to encode, sampled while `ready_o` is high |
| ready_o | output | 1 | High in the cycle where the next message is sampled |
| valid_o | output | 1 | High when `sdata_o` carries a codeword bit |
| sdata_o | output | 1 | Serial codeword output |

## Verification
On every cycle, the assertions check:
- the seven-cycle spacing of `ready_o`;
- that `valid_o` stays high once it rises;
- that the first bit sent equals the sampled `msg_i[0]`;
- that every completed codeword divides by g(x). A division register of the checker's own rebuilds the remainder from the serial line for this check.

Some behaviours only the bench scenarios can show:
- the exact bit values against a long-division reference for all sixteen messages;
- that message input toggled between samples is ignored;
- the reset values, including a reset in the middle of a codeword.

// File: rtl/serial_hamming_enc.sv
module serial_hamming_enc #(
  parameter int unsigned K = 4,
  parameter int unsigned R = 3,
  parameter logic [R-1:0] POLY = 3'b011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [K-1:0] msg_i,
  output logic         ready_o,
  output logic         valid_o,
  output logic         sdata_o
);
  localparam int unsigned N  = K + R;
  localparam int unsigned CW = $clog2(N);

  logic [CW-1:0] phase;
  logic [K-1:0]  sr;
  logic [R-1:0]  par, par_nxt;
  logic          in_msg, din, fb, valid_q, sdata_q;

  assign ready_o = (phase == '0);
  assign in_msg  = (phase < CW'(K));
  assign din     = ready_o ? msg_i[0] : sr[0];
  assign fb      = in_msg & (din ^ par[R-1]);
  assign par_nxt = {par[R-2:0], 1'b0} ^ (fb ? POLY : '0);
  assign valid_o = valid_q;
  assign sdata_o = sdata_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase   <= '0;
      sr      <= '0;
      par     <= '0;
      valid_q <= 1'b0;
      sdata_q <= 1'b0;
    end else begin
      phase   <= (phase == CW'(N - 1)) ? '0 : phase + 1'b1;
      sr      <= ready_o ? (msg_i >> 1) : (sr >> 1);
      par     <= par_nxt;
      valid_q <= 1'b1;
      sdata_q <= in_msg ? din : par[R-1];
    end
  end
endmodule

module serial_hamming_enc_chk #(
  parameter int unsigned K = 4,
  parameter int unsigned R = 3,
  parameter logic [R-1:0] POLY = 3'b011
) (
  input logic         clk,
  input logic         rst,
  input logic [K-1:0] msg_i,
  input logic         ready_o,
  input logic         valid_o,
  input logic         sdata_o
);
  localparam int unsigned N  = K + R;
  localparam int unsigned GW = $clog2(N + 1);

  logic [GW-1:0] gap;
  logic          seen;
  logic [R-1:0]  syn, syn_nxt;

  assign syn_nxt = {syn[R-2:0], sdata_o} ^ (syn[R-1] ? POLY : '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
      syn  <= '0;
    end else begin
      if (ready_o) begin
        gap  <= '0;
        seen <= 1'b1;
        syn  <= '0;
      end else begin
        gap <= gap + 1'b1;
        if (valid_o) syn <= syn_nxt;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |-> (ready_o && !valid_o && !sdata_o));

  a_r2_ready_period: assert property (@(posedge clk) disable iff (rst)
    seen |-> (ready_o == (gap == GW'(N - 1))));

  a_r2_ready_single: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  a_r3_valid_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> valid_o);

  a_r4_first_bit: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> (sdata_o == $past(msg_i[0])));

  a_r6_divisible: assert property (@(posedge clk) disable iff (rst)
    (ready_o && valid_o && seen) |-> (syn_nxt == '0));
endmodule

bind serial_hamming_enc serial_hamming_enc_chk #(.K(K), .R(R), .POLY(POLY)) chk_i (
  .clk(clk), .rst(rst), .msg_i(msg_i),
  .ready_o(ready_o), .valid_o(valid_o), .sdata_o(sdata_o)
);

// File: tb/serial_hamming_enc_tb_top.sv
module serial_hamming_enc_tb_top;
  typedef struct { logic b; string tag; } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] msg_i = 4'h0;
  logic       ready_o, valid_o, sdata_o;

  int   checks = 0, fails = 0;
  int   gap = 0;
  bit   seen = 0, mon_en = 0, done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  serial_hamming_enc dut_i (
    .clk(clk), .rst(rst), .msg_i(msg_i),
    .ready_o(ready_o), .valid_o(valid_o), .sdata_o(sdata_o)
  );

  function automatic logic [6:0] ref_seq(input logic [3:0] m);
    logic [6:0] v;
    logic [6:0] s;
    v = {m[0], m[1], m[2], m[3], 3'b000};
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b0001011 << (i - 3));
    s = {v[0], v[1], v[2], m[3], m[2], m[1], m[0]};
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic send_word(input logic [3:0] m, input bit junk);
    logic [6:0] s;
    exp_t e;
    while (!ready_o) @(negedge clk);
    msg_i = m;
    s = ref_seq(m);
    for (int i = 0; i < 7; i++) begin
      e.b = s[i];
      if (m == 4'h0)  e.tag = "R7";
      else if (junk)  e.tag = "R5";
      else            e.tag = (i < 4) ? "R4" : "R6";
      q.push_back(e);
    end
    @(negedge clk);
    if (junk)
      for (int j = 0; j < 6; j++) begin
        msg_i = ~m ^ 4'(j * 5);
        @(negedge clk);
      end
  endtask

  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (seen) gap++;
      if (ready_o) begin
        if (seen) begin
          check(gap == 7, "R2", ready_o, 1'b1);
          check(valid_o == 1'b1, "R7", valid_o, 1'b1);
        end
        gap = 0;
        seen = 1;
      end else if (seen) begin
        check(valid_o == 1'b1, "R3", valid_o, 1'b1);
      end
      if (valid_o && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(sdata_o === e.b, e.tag, sdata_o, e.b);
      end
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(ready_o === 1'b1, "R1", ready_o, 1'b1);
    check(valid_o === 1'b0, "R1", valid_o, 1'b0);
    check(sdata_o === 1'b0, "R1", sdata_o, 1'b0);
    rst = 1'b0;
    mon_en = 1;
    check(ready_o === 1'b1, "R1", ready_o, 1'b1);

    for (int m = 0; m < 16; m++) send_word(4'(m), 1'b0);
    send_word(4'h0, 1'b0);
    send_word(4'h0, 1'b0);
    send_word(4'hF, 1'b0);
    send_word(4'h0, 1'b0);
    send_word(4'h9, 1'b1);
    send_word(4'h6, 1'b1);
    send_word(4'h3, 1'b1);

    // reset in the middle of a codeword
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(ready_o === 1'b1, "R1", ready_o, 1'b1);
    check(valid_o === 1'b0, "R1", valid_o, 1'b0);
    check(sdata_o === 1'b0, "R1", sdata_o, 1'b0);
    q.delete();
    seen = 0;
    gap = 0;
    @(negedge clk);
    rst = 1'b0;
    check(ready_o === 1'b1, "R1", ready_o, 1'b1);

    send_word(4'hA, 1'b0);
    send_word(4'h5, 1'b1);
    send_word(4'hC, 1'b0);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    mon_en = 0;
    done = 1;
    report();
  end
endmodule